// File: doc/BRIEF.md
# Host-to-controller command mailbox

This block is a register-mapped mailbox between a host processor and a management controller. The host loads up to four 32-bit payload words and two 32-bit pointer values, then writes a single command word. That word carries the command code, a subcommand, the payload length in bytes and a flag that asks for an interrupt on completion. The command write starts a transaction: the mailbox goes busy and sends a one-cycle request, with the decoded fields, the payload and both pointers, to the controller.

The controller ends the transaction by pulsing its done input. With that pulse it returns an error flag, an 8-bit error code and four reply words. The mailbox then drops busy and stores the error result in its status register. It stores the replies in a read buffer. If the command asked for an interrupt, the mailbox also sets a pending bit that drives the interrupt line. The host either polls the busy bit or waits for the interrupt, and it clears the pending bit by writing one to it.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous active-low reset, every register and buffer reads zero and the interrupt output is low.
- R2: The command word at offset 0x00 is laid out as follows: code in bits 7:0, interrupt request in bit 8, subcommand in bits 15:12 and byte length in bits 20:16. A read of 0x00 returns the accepted fields in those positions, with all other bits zero.
- R3: A command write while idle sets busy on the next clock. On that same clock a one-cycle request goes to the controller, with the code, subcommand, length, payload and pointers presented.
- R4: While busy, writes to the command register, the pointer registers and the write buffer are ignored, and no new request is issued.
- R5: The status register is at offset 0x04, with busy in bit 0, error in bit 1, interrupt pending in bit 2 and the error code in bits 23:16. A done pulse while busy clears busy and captures the error flag and error code. A done pulse while idle changes nothing.
- R6: A done pulse while busy stores the four reply words in the read buffer at 0x90, 0x94, 0x98 and 0x9C. Reply word i comes from reply bits 32i+31:32i.
- R7: A done pulse sets interrupt pending only when the accepted command had bit 8 set. The interrupt output follows the pending bit.
- R8: A status write with bit 2 set clears interrupt pending and drops the interrupt. A status write with bit 2 clear has no effect, and status bits 0, 1 and 23:16 cannot be written.
- R9: An accepted command write clears the error bit and the error code.
- R10: The source pointer is at 0x08 and the destination pointer is at 0x0C. The write buffer occupies 0x80 to 0x8C, one whole word per write, and word i drives payload bits 32i+31:32i. All of these read back and pass to the controller unchanged.
- R11: Reads of unmapped offsets return zero, and host writes to the read buffer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 8 | Host byte address, word aligned |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr |
| ctl_req | output | 1 | One-cycle command request to the controller |
| ctl_code | output | 8 | Command code |
| ctl_sub | output | 4 | Subcommand |
| ctl_len | output | 5 | Payload length in bytes |
| ctl_sptr | output | 32 | Source pointer |
| ctl_dptr | output | 32 | Destination pointer |
| ctl_payload | output | 128 | Write-buffer words, word 0 lowest |
| ctl_done | input | 1 | Controller completion pulse |
| ctl_err | input | 1 | Error flag, valid with ctl_done |
| ctl_err_code | input | 8 | Error code, valid with ctl_done |
| ctl_reply | input | 128 | Reply words, valid with ctl_done |
| irq_out | output | 1 | Completion interrupt to the host |

## Verification
The assertions watch the handshake on every cycle. They check that an idle command write yields a single-cycle request and busy, that a busy command write starts nothing, that done ends busy, and that the interrupt rises only for commands that requested it and falls on acknowledge. Some behaviour shows only in the directed scenarios, because it needs values read back over the bus. These scenarios cover the field packing of the command and status words, that pointer and buffer contents are held while busy, reply capture, that the error code is cleared by the next command, and that unmapped and read-buffer offsets behave as required.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W     = 32;
    localparam int CODE_W     = 8;
    localparam int SUB_W      = 4;
    localparam int LEN_W      = 5;
    localparam int ECODE_W    = 8;

    // command word field positions
    localparam int CODE_LSB   = 0;
    localparam int IRQREQ_BIT = 8;
    localparam int SUB_LSB    = 12;
    localparam int LEN_LSB    = 16;

    // status word field positions
    localparam int ST_BUSY    = 0;
    localparam int ST_ERR     = 1;
    localparam int ST_PEND    = 2;
    localparam int ST_ECODE   = 16;

    // register offsets
    localparam logic [7:0] OFF_CMD  = 8'h00;
    localparam logic [7:0] OFF_STS  = 8'h04;
    localparam logic [7:0] OFF_SPTR = 8'h08;
    localparam logic [7:0] OFF_DPTR = 8'h0C;
    localparam logic [7:0] OFF_WBUF = 8'h80;
    localparam logic [7:0] OFF_RBUF = 8'h90;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              irq_req;
        logic [SUB_W-1:0]  sub;
        logic [LEN_W-1:0]  len;
    } cmd_fields_t;

    typedef struct packed {
        logic cmd;
        logic sts;
        logic sptr;
        logic dptr;
        logic wbuf;
        logic rbuf;
    } hit_t;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 4,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit,
    output logic [IDX_W-1:0]  wbuf_idx,
    output logic [IDX_W-1:0]  rbuf_idx
);

    localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(NUM_WORDS * 4);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(OFF_STS);
    localparam logic [ADDR_W-1:0] A_SPTR  = ADDR_W'(OFF_SPTR);
    localparam logic [ADDR_W-1:0] A_DPTR  = ADDR_W'(OFF_DPTR);
    localparam logic [ADDR_W-1:0] A_WBUF  = ADDR_W'(OFF_WBUF);
    localparam logic [ADDR_W-1:0] A_RBUF  = ADDR_W'(OFF_RBUF);

    logic [ADDR_W-1:0] woff;
    logic [ADDR_W-1:0] roff;

    always_comb begin
        woff     = addr - A_WBUF;
        roff     = addr - A_RBUF;
        hit      = '0;
        hit.cmd  = (addr == A_CMD);
        hit.sts  = (addr == A_STS);
        hit.sptr = (addr == A_SPTR);
        hit.dptr = (addr == A_DPTR);
        hit.wbuf = (addr >= A_WBUF) && (woff < SPAN);
        hit.rbuf = (addr >= A_RBUF) && (roff < SPAN);
        wbuf_idx = woff[IDX_W+1:2];
        rbuf_idx = roff[IDX_W+1:2];
    end

endmodule

// File: rtl/mbx_wordbuf.sv
module mbx_wordbuf
    import mbx_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int FLAT_W   = NUM_WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               ld_en,
    input  logic [FLAT_W-1:0]  ld_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [WORD_W-1:0]  rd_data,
    output logic [FLAT_W-1:0]  flat
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] words_d, words_q;

    always_comb begin
        words_d = words_q;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (ld_en) begin
                words_d[i] = ld_data[i*WORD_W +: WORD_W];
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                words_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
            assign flat[g*WORD_W +: WORD_W] = words_q[g];
        end
    endgenerate

    assign rd_data = words_q[rd_idx];

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic               sts_we,
    input  logic               sptr_we,
    input  logic               dptr_we,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               ctl_done,
    input  logic               ctl_err,
    input  logic [ECODE_W-1:0] ctl_err_code,
    output logic               busy,
    output logic               err,
    output logic               pend,
    output logic [ECODE_W-1:0] ecode,
    output cmd_fields_t        cmd,
    output logic               req,
    output logic [WORD_W-1:0]  sptr,
    output logic [WORD_W-1:0]  dptr,
    output logic               capture
);

    typedef struct packed {
        logic               busy;
        logic               err;
        logic               pend;
        logic [ECODE_W-1:0] ecode;
        cmd_fields_t        cmd;
        logic               req;
        logic [WORD_W-1:0]  sptr;
        logic [WORD_W-1:0]  dptr;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        accept;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        accept   = cmd_we && !st_q.busy;
        capture  = ctl_done && st_q.busy;

        if (accept) begin
            st_d.cmd.code    = wdata[CODE_LSB +: CODE_W];
            st_d.cmd.irq_req = wdata[IRQREQ_BIT];
            st_d.cmd.sub     = wdata[SUB_LSB +: SUB_W];
            st_d.cmd.len     = wdata[LEN_LSB +: LEN_W];
            st_d.busy        = 1'b1;
            st_d.req         = 1'b1;
            st_d.err         = 1'b0;
            st_d.ecode       = '0;
        end
        if (sptr_we && !st_q.busy) begin
            st_d.sptr = wdata;
        end
        if (dptr_we && !st_q.busy) begin
            st_d.dptr = wdata;
        end
        if (sts_we && wdata[ST_PEND]) begin
            st_d.pend = 1'b0;
        end
        // completion outranks a same-cycle acknowledge
        if (capture) begin
            st_d.busy  = 1'b0;
            st_d.err   = ctl_err;
            st_d.ecode = ctl_err_code;
            if (st_q.cmd.irq_req) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign err   = st_q.err;
    assign pend  = st_q.pend;
    assign ecode = st_q.ecode;
    assign cmd   = st_q.cmd;
    assign req   = st_q.req;
    assign sptr  = st_q.sptr;
    assign dptr  = st_q.dptr;

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 4,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int FLAT_W   = NUM_WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               ctl_req,
    output logic [CODE_W-1:0]  ctl_code,
    output logic [SUB_W-1:0]   ctl_sub,
    output logic [LEN_W-1:0]   ctl_len,
    output logic [WORD_W-1:0]  ctl_sptr,
    output logic [WORD_W-1:0]  ctl_dptr,
    output logic [FLAT_W-1:0]  ctl_payload,
    input  logic               ctl_done,
    input  logic               ctl_err,
    input  logic [ECODE_W-1:0] ctl_err_code,
    input  logic [FLAT_W-1:0]  ctl_reply,
    output logic               irq_out
);

    hit_t               hit;
    logic [IDX_W-1:0]   wbuf_idx;
    logic [IDX_W-1:0]   rbuf_idx;
    logic               busy_w;
    logic               err_w;
    logic               pend_w;
    logic [ECODE_W-1:0] ecode_w;
    cmd_fields_t        cmd_w;
    logic               capture_w;
    logic [WORD_W-1:0]  wbuf_rd;
    logic [WORD_W-1:0]  rbuf_rd;
    logic [FLAT_W-1:0]  rbuf_flat;

    mbx_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .addr     (bus_addr),
        .hit      (hit),
        .wbuf_idx (wbuf_idx),
        .rbuf_idx (rbuf_idx)
    );

    mbx_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (bus_we && hit.cmd),
        .sts_we       (bus_we && hit.sts),
        .sptr_we      (bus_we && hit.sptr),
        .dptr_we      (bus_we && hit.dptr),
        .wdata        (bus_wdata),
        .ctl_done     (ctl_done),
        .ctl_err      (ctl_err),
        .ctl_err_code (ctl_err_code),
        .busy         (busy_w),
        .err          (err_w),
        .pend         (pend_w),
        .ecode        (ecode_w),
        .cmd          (cmd_w),
        .req          (ctl_req),
        .sptr         (ctl_sptr),
        .dptr         (ctl_dptr),
        .capture      (capture_w)
    );

    mbx_wordbuf #(.NUM_WORDS(NUM_WORDS)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && hit.wbuf && !busy_w),
        .wr_idx  (wbuf_idx),
        .wr_data (bus_wdata),
        .ld_en   (1'b0),
        .ld_data ('0),
        .rd_idx  (wbuf_idx),
        .rd_data (wbuf_rd),
        .flat    (ctl_payload)
    );

    mbx_wordbuf #(.NUM_WORDS(NUM_WORDS)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (1'b0),
        .wr_idx  ('0),
        .wr_data ('0),
        .ld_en   (capture_w),
        .ld_data (ctl_reply),
        .rd_idx  (rbuf_idx),
        .rd_data (rbuf_rd),
        .flat    (rbuf_flat)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit.cmd) begin
            bus_rdata[CODE_LSB +: CODE_W] = cmd_w.code;
            bus_rdata[IRQREQ_BIT]         = cmd_w.irq_req;
            bus_rdata[SUB_LSB +: SUB_W]   = cmd_w.sub;
            bus_rdata[LEN_LSB +: LEN_W]   = cmd_w.len;
        end else if (hit.sts) begin
            bus_rdata[ST_BUSY]               = busy_w;
            bus_rdata[ST_ERR]                = err_w;
            bus_rdata[ST_PEND]               = pend_w;
            bus_rdata[ST_ECODE +: ECODE_W]   = ecode_w;
        end else if (hit.sptr) begin
            bus_rdata = ctl_sptr;
        end else if (hit.dptr) begin
            bus_rdata = ctl_dptr;
        end else if (hit.wbuf) begin
            bus_rdata = wbuf_rd;
        end else if (hit.rbuf) begin
            bus_rdata = rbuf_rd;
        end
    end

    assign ctl_code = cmd_w.code;
    assign ctl_sub  = cmd_w.sub;
    assign ctl_len  = cmd_w.len;
    assign irq_out  = pend_w;

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              ack_bit,
    input logic              busy,
    input logic              cmd_irq,
    input logic              ctl_req,
    input logic              ctl_done,
    input logic              irq_out
);

    logic cmd_wr;
    logic sts_ack;
    assign cmd_wr  = bus_we && (bus_addr == ADDR_W'(OFF_CMD));
    assign sts_ack = bus_we && (bus_addr == ADDR_W'(OFF_STS)) && ack_bit;

    a_r3_accept_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (ctl_req && busy));

    a_r3_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_req |=> !ctl_req);

    a_r4_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !ctl_done) |=> (busy && !ctl_req));

    a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_done) |=> !busy);

    a_r7_irq_on_requested_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_done && cmd_irq) |=> irq_out);

    a_r7_no_irq_unrequested: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_done && !cmd_irq && !irq_out && !sts_ack) |=> !irq_out);

    a_r8_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ack && !(busy && ctl_done)) |=> !irq_out);

endmodule

bind cmd_mailbox mbx_checker #(.ADDR_W(ADDR_W)) u_mbx_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .ack_bit  (bus_wdata[2]),
    .busy     (busy_w),
    .cmd_irq  (cmd_w.irq_req),
    .ctl_req  (ctl_req),
    .ctl_done (ctl_done),
    .irq_out  (irq_out)
);

// File: tb/tb_cmd_mailbox.sv
`timescale 1ns/1ps
module tb_cmd_mailbox;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         ctl_req;
    logic [7:0]   ctl_code;
    logic [3:0]   ctl_sub;
    logic [4:0]   ctl_len;
    logic [31:0]  ctl_sptr;
    logic [31:0]  ctl_dptr;
    logic [127:0] ctl_payload;
    logic         ctl_done = 1'b0;
    logic         ctl_err = 1'b0;
    logic [7:0]   ctl_err_code = '0;
    logic [127:0] ctl_reply = '0;
    logic         irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    cmd_mailbox dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_req(ctl_req),
        .ctl_code(ctl_code), .ctl_sub(ctl_sub), .ctl_len(ctl_len),
        .ctl_sptr(ctl_sptr), .ctl_dptr(ctl_dptr), .ctl_payload(ctl_payload),
        .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code),
        .ctl_reply(ctl_reply), .irq_out(irq_out)
    );

    function automatic logic [31:0] cmd_word(input logic [7:0] code, input logic irq,
                                             input logic [3:0] sub, input logic [4:0] len);
        return {11'b0, len, sub, 3'b0, irq, code};
    endfunction

    function automatic logic [31:0] sts_word(input logic busy, input logic err,
                                             input logic pend, input logic [7:0] ec);
        return {8'b0, ec, 13'b0, pend, err, busy};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] got, input logic [127:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, $sformatf("read %02h", a), {96'b0, v}, {96'b0, exp});
    endtask

    task automatic finish_cmd(input logic e, input logic [7:0] ec, input logic [127:0] rep);
        @(negedge clk);
        ctl_done = 1'b1; ctl_err = e; ctl_err_code = ec; ctl_reply = rep;
        @(negedge clk);
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0; ctl_reply = '0;
    endtask

    task automatic t_reset();
        rd_check("R1", 8'h00, 32'h0);
        rd_check("R1", 8'h04, 32'h0);
        rd_check("R1", 8'h08, 32'h0);
        rd_check("R1", 8'h84, 32'h0);
        rd_check("R1", 8'h9C, 32'h0);
        check("R1", "irq", {127'b0, irq_out}, 128'h0);
    endtask

    task automatic t_poll_cmd();
        logic [127:0] rep;
        wr(8'h08, 32'hA000_1000);
        wr(8'h0C, 32'hB000_2000);
        wr(8'h80, 32'h1111_0001);
        wr(8'h84, 32'h2222_0002);
        wr(8'h88, 32'h3333_0003);
        wr(8'h8C, 32'h4444_0004);
        wr(8'h00, cmd_word(8'h5A, 1'b0, 4'h3, 5'd8) | 32'hFFE0_0E00);
        check("R3", "req", {127'b0, ctl_req}, 128'h1);
        check("R3", "code", {120'b0, ctl_code}, {120'b0, 8'h5A});
        check("R3", "sub", {124'b0, ctl_sub}, {124'b0, 4'h3});
        check("R3", "len", {123'b0, ctl_len}, {123'b0, 5'd8});
        check("R10", "sptr", {96'b0, ctl_sptr}, {96'b0, 32'hA000_1000});
        check("R10", "dptr", {96'b0, ctl_dptr}, {96'b0, 32'hB000_2000});
        check("R10", "payload", ctl_payload,
              {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001});
        rd_check("R2", 8'h00, cmd_word(8'h5A, 1'b0, 4'h3, 5'd8));
        check("R3", "req one cycle", {127'b0, ctl_req}, 128'h0);
        rd_check("R5", 8'h04, sts_word(1'b1, 1'b0, 1'b0, 8'h00));
        rd_check("R10", 8'h88, 32'h3333_0003);
        rep = {32'hDDDD_0004, 32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001};
        finish_cmd(1'b0, 8'h00, rep);
        rd_check("R5", 8'h04, sts_word(1'b0, 1'b0, 1'b0, 8'h00));
        check("R7", "no irq without request", {127'b0, irq_out}, 128'h0);
        rd_check("R6", 8'h90, 32'hAAAA_0001);
        rd_check("R6", 8'h94, 32'hBBBB_0002);
        rd_check("R6", 8'h98, 32'hCCCC_0003);
        rd_check("R6", 8'h9C, 32'hDDDD_0004);
    endtask

    task automatic t_busy_ignore();
        wr(8'h00, cmd_word(8'h21, 1'b0, 4'h1, 5'd4));
        check("R3", "req", {127'b0, ctl_req}, 128'h1);
        wr(8'h00, cmd_word(8'h77, 1'b1, 4'hF, 5'd16));
        check("R4", "no second req", {127'b0, ctl_req}, 128'h0);
        rd_check("R4", 8'h00, cmd_word(8'h21, 1'b0, 4'h1, 5'd4));
        wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h0C, 32'hFEED_F00D);
        wr(8'h80, 32'h0BAD_0BAD);
        rd_check("R4", 8'h08, 32'hA000_1000);
        rd_check("R4", 8'h0C, 32'hB000_2000);
        rd_check("R4", 8'h80, 32'h1111_0001);
        check("R4", "code held", {120'b0, ctl_code}, {120'b0, 8'h21});
        finish_cmd(1'b0, 8'h00, '0);
        rd_check("R4", 8'h04, sts_word(1'b0, 1'b0, 1'b0, 8'h00));
    endtask

    task automatic t_irq_err();
        wr(8'h00, cmd_word(8'h33, 1'b1, 4'h2, 5'd16));
        check("R2", "len 16", {123'b0, ctl_len}, {123'b0, 5'd16});
        finish_cmd(1'b1, 8'h07, {4{32'h5555_AAAA}});
        check("R7", "irq set", {127'b0, irq_out}, 128'h1);
        rd_check("R5", 8'h04, sts_word(1'b0, 1'b1, 1'b1, 8'h07));
        wr(8'h04, 32'h00FF_0003);
        rd_check("R8", 8'h04, sts_word(1'b0, 1'b1, 1'b1, 8'h07));
        check("R8", "irq kept", {127'b0, irq_out}, 128'h1);
        wr(8'h04, 32'h0000_0004);
        check("R8", "irq cleared", {127'b0, irq_out}, 128'h0);
        rd_check("R8", 8'h04, sts_word(1'b0, 1'b1, 1'b0, 8'h07));
        wr(8'h00, cmd_word(8'h01, 1'b0, 4'h0, 5'd0));
        rd_check("R9", 8'h04, sts_word(1'b1, 1'b0, 1'b0, 8'h00));
        finish_cmd(1'b0, 8'h00, {4{32'h1234_5678}});
    endtask

    task automatic t_idle_done();
        finish_cmd(1'b1, 8'h99, {4{32'hFFFF_FFFF}});
        rd_check("R5", 8'h04, sts_word(1'b0, 1'b0, 1'b0, 8'h00));
        rd_check("R6", 8'h94, 32'h1234_5678);
        check("R7", "idle done no irq", {127'b0, irq_out}, 128'h0);
    endtask

    task automatic t_unmapped();
        wr(8'h90, 32'hCAFE_CAFE);
        rd_check("R11", 8'h90, 32'h1234_5678);
        rd_check("R11", 8'h10, 32'h0);
        rd_check("R11", 8'h40, 32'h0);
        rd_check("R11", 8'hA0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_poll_cmd();
        t_busy_ignore();
        t_irq_err();
        t_idle_done();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule